// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Controller

This block watches a bank of general-purpose input pins and keeps one sticky pending flag per pin. A pin can raise its flag only while software has enabled its interrupt, selected plain GPIO use for it, and set it as an input. A per-pin polarity bit picks whether a rising or a falling transition counts. Each pin is brought into the clock domain through a two-flop synchronizer, and a transition is found by comparing the synchronized level with its sample from the cycle before.

Pending flags are cleared by writing ones to a clear register. A single summary bit, which drives the interrupt output, is set whenever any pending flag sets. Software must clear the summary bit with its own write. If pending flags are still set when it does, the summary bit stays high. Software reaches all registers over a simple synchronous bus. A write is taken on the rising clock edge while `bus_wr` is high. Read data is combinational from the word address.

Top module: `gpio_edge_irq`

## Requirements
- R1: The status register (word address 4) holds pin n's pending flag in bit n for pins 0 to 22; bits 31:23 always read as zero.
- R2: Every status bit resets to 0, and a bus write to word address 4 changes no status bit.
- R3: A pin's status bit can set only while its enable bit (address 0) is 1, its select bit (address 1) is 1 for GPIO use, and its direction bit (address 2) is 0 for input; any other combination never sets it.
- R4: Polarity bit 0 (address 3) arms a pin on rising transitions and 1 on falling ones. Through the synchronizer, the status bit is first readable after the third rising clock edge that follows the pin change, and not after the second.
- R5: Writing 1 to bit n of the clear register (address 5) clears status bit n; a 0 bit leaves that status bit unchanged; the clear register reads as zero.
- R6: Any status bit changing to 1 sets the summary bit (bit 0 of address 6), and `irq_o` equals the summary bit.
- R7: Clearing every status bit leaves the summary bit set; only writing 1 to bit 0 of address 6 clears it.
- R8: A summary clear written while any status bit is 1 leaves the summary bit at 1.
- R9: When a qualified edge and a clear write hit the same status bit in one cycle, the bit ends set; the same holds for the summary bit against a summary clear.
- R10: Enable, select, direction and polarity registers reset to 0, read back what was written in bits 22:0, and read zero in bits 31:23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_i | input | 23 | Raw, asynchronous pin levels |
| irq_o | output | 1 | Interrupt, equal to the summary bit |

## Verification
The assertions assume a pin change is first seen by the detector two edges after it occurs, so a qualifier that is steady across those edges decides the outcome. They also assume the single bus never writes the clear and the summary registers in the same cycle. The stimulus changes configuration only while pins are steady. It changes pins only at falling clock edges, with several idle cycles before any result is sampled. In the collision tests, it places the clear write exactly on the cycle when the flag sets.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register addresses for the GPIO edge interrupt block.
// Assumes a word-addressed bus; these addresses are the software contract.
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_ENABLE  = 3'd0,
        RA_SELECT  = 3'd1,
        RA_DIR     = 3'd2,
        RA_POLAR   = 3'd3,
        RA_STATUS  = 3'd4,
        RA_CLEAR   = 3'd5,
        RA_SUMMARY = 3'd6
    } reg_addr_e;

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Two-flop synchronizer per pin, plus a third stage that holds the previous
// synchronized level. Reports one-cycle rise and fall pulses per pin.
// Assumes pins are asynchronous levels that stay put for at least two clocks.
module gpio_pin_sync #(
    parameter int unsigned NUM_PINS = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic meta_q, sync_q, prev_q;

        // Purpose: bring the pin in and remember its last synchronized level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[p];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // Purpose: compare the current level with the last one to find transitions.
        always_comb begin
            rise_o[p] = sync_q & ~prev_q;
            fall_o[p] = ~sync_q & prev_q;
        end
    end

endmodule

// File: rtl/gpio_edge_qual.sv
// Module: gpio_edge_qual
// Combinational per-pin qualifier. A pin hits when it is enabled, set to GPIO
// use, set as input, and the transition matches its polarity (0 rise, 1 fall).
// Assumes edge pulses last one cycle.
module gpio_edge_qual #(
    parameter int unsigned NUM_PINS = 23
) (
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] fall_i,
    input  logic [NUM_PINS-1:0] ien_i,
    input  logic [NUM_PINS-1:0] sel_i,
    input  logic [NUM_PINS-1:0] dir_i,
    input  logic [NUM_PINS-1:0] pol_i,
    output logic [NUM_PINS-1:0] hit_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_qual
        logic armed;
        logic edge_seen;

        // Purpose: gate detection and pick the active transition for this pin.
        always_comb begin
            armed     = ien_i[p] & sel_i[p] & ~dir_i[p];
            edge_seen = pol_i[p] ? fall_i[p] : rise_i[p];
            hit_o[p]  = armed & edge_seen;
        end
    end

endmodule

// File: rtl/gpio_irq_regs.sv
// Module: gpio_irq_regs
// Register file: four read/write configuration registers, a sticky status
// register with write-one-to-clear, and a sticky summary bit that re-arms.
// Assumes one bus write per cycle; a set always wins over a clear.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 23,
    parameter int unsigned REG_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    input  logic [NUM_PINS-1:0] hit_i,
    output logic [NUM_PINS-1:0] ien_o,
    output logic [NUM_PINS-1:0] sel_o,
    output logic [NUM_PINS-1:0] dir_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] pend_o,
    output logic [NUM_PINS-1:0] clr_mask_o,
    output logic                sum_clr_o,
    output logic                summary_o
);

    localparam int unsigned PAD_W = REG_W - NUM_PINS;

    logic [NUM_PINS-1:0] ien_q, sel_q, dir_q, pol_q, pend_q;
    logic                summary_q;
    logic [NUM_PINS-1:0] wr_bits;
    logic                unused_hi;

    assign wr_bits   = wdata[NUM_PINS-1:0];
    assign unused_hi = ^wdata[REG_W-1:NUM_PINS];

    // Purpose: decode the clear strobes from the bus.
    always_comb begin
        clr_mask_o = (wr_en && addr == RA_CLEAR) ? wr_bits : '0;
        sum_clr_o  = wr_en && addr == RA_SUMMARY && wdata[0];
    end

    // Purpose: hold the four configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
            sel_q <= '0;
            dir_q <= '0;
            pol_q <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_ENABLE: ien_q <= wr_bits;
                RA_SELECT: sel_q <= wr_bits;
                RA_DIR:    dir_q <= wr_bits;
                RA_POLAR:  pol_q <= wr_bits;
                default:   ;
            endcase
        end
    end

    // Purpose: sticky pending flags, cleared by ones, with set beating clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask_o) | hit_i;
        end
    end

    // Purpose: sticky summary bit that cannot drop while flags are pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            summary_q <= 1'b0;
        end else begin
            summary_q <= (|hit_i) | (summary_q & ~sum_clr_o) | (sum_clr_o & (|pend_q));
        end
    end

    // Purpose: return the addressed register, padded with zeros.
    always_comb begin
        case (addr)
            RA_ENABLE:  rdata = {{PAD_W{1'b0}}, ien_q};
            RA_SELECT:  rdata = {{PAD_W{1'b0}}, sel_q};
            RA_DIR:     rdata = {{PAD_W{1'b0}}, dir_q};
            RA_POLAR:   rdata = {{PAD_W{1'b0}}, pol_q};
            RA_STATUS:  rdata = {{PAD_W{1'b0}}, pend_q};
            RA_SUMMARY: rdata = {{(REG_W-1){1'b0}}, summary_q};
            default:    rdata = '0;
        endcase
    end

    assign ien_o     = ien_q;
    assign sel_o     = sel_q;
    assign dir_o     = dir_q;
    assign pol_o     = pol_q;
    assign pend_o    = pend_q;
    assign summary_o = summary_q;

endmodule

// File: rtl/gpio_edge_irq.sv
// Module: gpio_edge_irq (top)
// Synchronizes the pins, qualifies edges per pin and keeps sticky status
// plus a summary interrupt. Assumes a single synchronous bus master.
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 23,
    parameter int unsigned REG_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic                irq_o
);

    logic [NUM_PINS-1:0] rise, fall, hit;
    logic [NUM_PINS-1:0] ien, sel, dir, pol, pend, clr_mask;
    logic                sum_clr, summary;

    gpio_pin_sync #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_edge_qual #(.NUM_PINS(NUM_PINS)) qual_i (
        .rise_i (rise),
        .fall_i (fall),
        .ien_i  (ien),
        .sel_i  (sel),
        .dir_i  (dir),
        .pol_i  (pol),
        .hit_o  (hit)
    );

    gpio_irq_regs #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .hit_i      (hit),
        .ien_o      (ien),
        .sel_o      (sel),
        .dir_o      (dir),
        .pol_o      (pol),
        .pend_o     (pend),
        .clr_mask_o (clr_mask),
        .sum_clr_o  (sum_clr),
        .summary_o  (summary)
    );

    assign irq_o = summary;

endmodule

// File: rtl/gpio_irq_chk.sv
// Module: gpio_irq_chk
// Property checker bound to gpio_edge_irq.
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 23,
    parameter int unsigned REG_W    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic [REG_W-1:0]    rdata,
    input logic [NUM_PINS-1:0] ien,
    input logic [NUM_PINS-1:0] sel,
    input logic [NUM_PINS-1:0] dir,
    input logic [NUM_PINS-1:0] pend,
    input logic [NUM_PINS-1:0] clr_mask,
    input logic                sum_clr,
    input logic                summary
);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == RA_STATUS) |-> (rdata[REG_W-1:NUM_PINS] == '0));

    a_r3_qualified_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & ~$past(ien & sel & ~dir)) == '0);

    a_r5_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) & ~pend & ~$past(clr_mask)) == '0);

    a_r6_summary_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ~$past(pend))) |-> summary);

    a_r7_summary_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(summary) |-> $past(sum_clr));

    a_r8_summary_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_clr && (|pend)) |=> summary);

endmodule

bind gpio_edge_irq gpio_irq_chk #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .rdata    (bus_rdata),
    .ien      (ien),
    .sel      (sel),
    .dir      (dir),
    .pend     (pend),
    .clr_mask (clr_mask),
    .sum_clr  (sum_clr),
    .summary  (summary)
);

// File: tb/gpio_edge_irq_tb_top.sv
module gpio_edge_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 23;
    localparam logic [31:0] PIN_MASK = 32'h007F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_i = '0;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    gpio_edge_irq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [N-1:0] en, sl, dr, pl, qual, expv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R10: reset state of every register
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R2/R10 reset value", v, 32'h0);
        end
        chk("R6 irq after reset", {31'b0, irq_o}, 32'h0);

        // R10: configuration read back, upper bits zero
        for (int a = 0; a < 4; a++) begin
            wr(3'(a), 32'hFFFF_FFFF);
            rd(3'(a), v);
            chk("R10 config all ones", v, PIN_MASK);
            wr(3'(a), 32'hA5A5_5A5A);
            rd(3'(a), v);
            chk("R10 config pattern", v, 32'hA5A5_5A5A & PIN_MASK);
            wr(3'(a), 32'h0);
        end

        // R2: status write ignored; R5: clear register reads zero
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v);
        chk("R2 status write ignored", v, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v);
        chk("R5 clear reads zero", v, 32'h0);

        // R3 R4 R5 R6 R7 R8: sweep of all 16 qualifier/polarity combinations per pin
        for (int r = 0; r < 16; r++) begin
            for (int p = 0; p < N; p++) begin
                int c;
                c = (p + r) % 16;
                en[p] = c[0]; sl[p] = c[1]; dr[p] = c[2]; pl[p] = c[3];
            end
            qual = en & sl & ~dr;
            wr(3'd0, {9'b0, en});
            wr(3'd1, {9'b0, sl});
            wr(3'd2, {9'b0, dr});
            wr(3'd3, {9'b0, pl});
            settle();
            rd(3'd4, v);
            chk("R3 config write makes no edge", v, 32'h0);

            // rising transitions on every pin
            pin_i = '1;
            settle();
            expv = qual & ~pl;
            rd(3'd4, v);
            chk("R3/R4 rise pending", v, {9'b0, expv});
            chk("R6 irq after rise", {31'b0, irq_o}, {31'b0, |expv});
            if (|expv) begin
                wr(3'd6, 32'h1);
                chk("R8 summary stays while pending", {31'b0, irq_o}, 32'h1);
                wr(3'd5, 32'h0);
                rd(3'd4, v);
                chk("R5 zero clear no effect", v, {9'b0, expv});
                wr(3'd5, 32'h0055_5555);
                rd(3'd4, v);
                chk("R5 partial clear", v, {9'b0, expv & ~23'h55_5555});
                wr(3'd5, PIN_MASK);
                rd(3'd4, v);
                chk("R5 full clear", v, 32'h0);
                chk("R7 summary survives status clear", {31'b0, irq_o}, 32'h1);
                wr(3'd6, 32'h1);
                chk("R7 summary cleared by write", {31'b0, irq_o}, 32'h0);
            end

            // falling transitions on every pin
            pin_i = '0;
            settle();
            expv = qual & pl;
            rd(3'd4, v);
            chk("R3/R4 fall pending", v, {9'b0, expv});
            chk("R6 irq after fall", {31'b0, irq_o}, {31'b0, |expv});
            wr(3'd5, PIN_MASK);
            wr(3'd6, 32'h1);
            chk("R7 irq low after both clears", {31'b0, irq_o}, 32'h0);
        end

        // R4: latency through the synchronizer, pin 0 rising
        wr(3'd0, 32'h1); wr(3'd1, 32'h1); wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        settle();
        pin_i[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd4, v);
        chk("R4 not yet after two edges", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(3'd4, v);
        chk("R4 visible after third edge", v, 32'h1);
        wr(3'd5, PIN_MASK); wr(3'd6, 32'h1);
        pin_i[0] = 1'b0;
        settle();

        // R9: edge and status clear in the same cycle
        pin_i[0] = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(3'd4, v);
        chk("R9 set beats status clear", v, 32'h1);
        wr(3'd5, PIN_MASK); wr(3'd6, 32'h1);
        chk("R9 setup summary low", {31'b0, irq_o}, 32'h0);
        pin_i[0] = 1'b0;
        settle();

        // R9: edge and summary clear in the same cycle
        pin_i[0] = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 set beats summary clear", {31'b0, irq_o}, 32'h1);
        rd(3'd6, v);
        chk("R6 summary register reads set", v, 32'h1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule